// File: doc/BRIEF.md
# Fault Record Capture Controller

This block keeps a running picture of fault conditions and, when asked, stores that picture as a permanent record in a small non-volatile area. Sixteen fault lines, split into a low byte and a high byte, feed two sticky status registers. When the sequencing logic raises a capture request, the controller freezes the register contents as a snapshot. It then writes an eight-byte record into the next free slot of a sixteen-slot, write-once record area. Each byte is written at a fixed pace, so one record takes eight byte-write periods.

The record area sits outside the block and is reached through a plain byte port: a write strobe, an address, write data and combinational read data. After reset the controller walks the slots and reads each one's first byte. The first slot whose first byte still reads as erased (0xFF) becomes the write position, so slots that already hold records are never written again. Once the last slot has been written, or the scan finds no erased slot, the controller reports full and drops all further requests.

Top module: `fault_record_ctrl`

## Requirements
- R1: Each status bit is set in the cycle after its fault line is sampled high and stays set until a capture is accepted. `stat_lo_o` mirrors `flt_lo_i` and `stat_hi_o` mirrors `flt_hi_i`, bit for bit.
- R2: At the clock edge that accepts a capture, the snapshot takes the OR of the status registers and the fault lines, and the status registers clear to zero. Fault activity after that edge does not alter the record being written.
- R3: A record in slot s occupies addresses 8*s to 8*s+7 and holds these bytes: a header 0x50|s, then the low snapshot byte, the high snapshot byte, the inverted low byte and the inverted high byte, then three bytes of 0x00.
- R4: The first byte strobe comes in the cycle after acceptance. Each strobe lasts one cycle, and strobes are spaced BYTE_CYCLES cycles apart in address order. `busy_o` stays high for 8*BYTE_CYCLES cycles after acceptance.
- R5: The controller writes only to bytes that read as 0xFF, and it writes each address of a slot exactly once.
- R6: After reset the controller scans one slot per cycle from slot 0, holding `busy_o` high. The first slot whose first byte reads 0xFF becomes the write position, and slots written later follow in increasing order.
- R7: A capture request that arrives while `busy_o` is high is ignored and leaves no trace once the current record is done.
- R8: `full_o` rises after the record in the last slot has been written, or when the scan finds no erased slot. While it is high, requests cause no write and `busy_o` stays low.
- R9: While reset is held, `busy_o` is high, `full_o` is low, no strobe is issued and both status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flt_lo_i | input | 8 | Fault lines for the low status register |
| flt_hi_i | input | 8 | Fault lines for the high status register |
| cap_req_i | input | 1 | Capture request from the sequencing logic |
| mem_we_o | output | 1 | One-cycle byte write strobe |
| mem_addr_o | output | 7 | Byte address into the record area |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_rdata_i | input | 8 | Combinational read data at `mem_addr_o` |
| stat_lo_o | output | 8 | Low status register |
| stat_hi_o | output | 8 | High status register |
| busy_o | output | 1 | Scanning or writing a record |
| full_o | output | 1 | No free slot remains |

## Verification
The bench targets faults that change during a write. A design without a frozen snapshot would store those later faults in the record. It also raises requests in the middle of a record; a design that accepted them would restart the pacing or jump to the next slot early. Reset is applied over partly and fully programmed areas. A wrong scan would overwrite a programmed byte, which the write-once memory model reports, or would fail to raise full. Requests made after the last slot is used check that full really blocks writes.

// File: rtl/fr_pkg.sv
// Shared constants and the controller state type for the fault record capture block.
package fr_pkg;
    localparam int         REC_BYTES = 8;       // bytes in one record
    localparam logic [7:0] ERASED    = 8'hFF;   // value of an unprogrammed byte
    localparam logic [7:0] HDR_TAG   = 8'h50;   // header tag OR-ed with the slot number

    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WRITE = 2'd2
    } fr_state_e;
endpackage

// File: rtl/fr_status_latch.sv
// Sticky fault status registers with a snapshot copy.
// Assumes: take_i is a single-cycle pulse issued by the controller when a
// capture is accepted; fault lines are synchronous to clk.
module fr_status_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  logic [W-1:0] flt_lo_i,
    input  logic [W-1:0] flt_hi_i,
    output logic [W-1:0] stat_lo_o,
    output logic [W-1:0] stat_hi_o,
    output logic [W-1:0] snap_lo_o,
    output logic [W-1:0] snap_hi_o
);
    logic [2*W-1:0] stat_q;
    logic [2*W-1:0] snap_q;
    logic [2*W-1:0] flt_w;

    assign flt_w = {flt_hi_i, flt_lo_i};

    // Accumulate faults; on take, move everything seen so far into the snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            snap_q <= '0;
        end else if (take_i) begin
            snap_q <= stat_q | flt_w;
            stat_q <= '0;
        end else begin
            stat_q <= stat_q | flt_w;
        end
    end

    assign stat_lo_o = stat_q[W-1:0];
    assign stat_hi_o = stat_q[2*W-1:W];
    assign snap_lo_o = snap_q[W-1:0];
    assign snap_hi_o = snap_q[2*W-1:W];

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R1
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(snap_q)); // R2
endmodule

// File: rtl/fr_byte_pacer.sv
// Paces one record as REC_BYTES byte slots of BYTE_CYCLES cycles each.
// Assumes: start_i arrives only while no record is in progress.
module fr_byte_pacer import fr_pkg::*; #(
    parameter int BYTE_CYCLES = 62500,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             strobe_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o,
    output logic             active_o
);
    localparam int               CNT_W    = $clog2(BYTE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_BYTES - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    // Count cycles inside each byte period and step through the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            idx_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            idx_q    <= '0;
        end else if (active_q) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                if (idx_q == IDX_LAST) begin
                    active_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign strobe_o = active_q && (cnt_q == '0);
    assign done_o   = active_q && (cnt_q == CNT_LAST) && (idx_q == IDX_LAST);
    assign idx_o    = idx_q;
    assign active_o = active_q;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !active_q); // R7
endmodule

// File: rtl/fr_record_fmt.sv
// Selects the record byte for a given index from the header and snapshot.
// Assumes: the slot number fits in eight bits; purely combinational.
module fr_record_fmt import fr_pkg::*; #(
    parameter int SLOT_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [7:0]        snap_lo_i,
    input  logic [7:0]        snap_hi_i,
    output logic [7:0]        byte_o
);
    // Map the byte index onto the record layout.
    always_comb begin
        case (idx_i)
            IDX_W'(0): byte_o = HDR_TAG | 8'(slot_i);
            IDX_W'(1): byte_o = snap_lo_i;
            IDX_W'(2): byte_o = snap_hi_i;
            IDX_W'(3): byte_o = ~snap_lo_i;
            IDX_W'(4): byte_o = ~snap_hi_i;
            default:   byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/fault_record_ctrl.sv
// Fault record capture controller: scans the record area after reset,
// accepts capture requests, and writes one paced eight-byte record per request.
// Assumes: mem_rdata_i reflects mem_addr_o within the same cycle, and the
// record area is only erased while the block is held in reset.
module fault_record_ctrl import fr_pkg::*; #(
    parameter  int SLOTS       = 16,
    parameter  int BYTE_CYCLES = 62500,
    localparam int SLOT_W      = $clog2(SLOTS),
    localparam int IDX_W       = $clog2(REC_BYTES),
    localparam int ADDR_W      = SLOT_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        flt_lo_i,
    input  logic [7:0]        flt_hi_i,
    input  logic              cap_req_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [7:0]        stat_lo_o,
    output logic [7:0]        stat_hi_o,
    output logic              busy_o,
    output logic              full_o
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    fr_state_e         state_q;
    logic [SLOT_W-1:0] slot_q;
    logic              full_q;
    logic              accept;
    logic              strobe;
    logic              rec_done;
    logic              pacer_active;
    logic [IDX_W-1:0]  byte_idx;
    logic [7:0]        snap_lo;
    logic [7:0]        snap_hi;

    // A request counts only when idle and a free slot remains.
    assign accept = (state_q == ST_IDLE) && cap_req_i && !full_q;

    fr_status_latch #(.W(8)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (accept),
        .flt_lo_i  (flt_lo_i),
        .flt_hi_i  (flt_hi_i),
        .stat_lo_o (stat_lo_o),
        .stat_hi_o (stat_hi_o),
        .snap_lo_o (snap_lo),
        .snap_hi_o (snap_hi)
    );

    fr_byte_pacer #(.BYTE_CYCLES(BYTE_CYCLES), .IDX_W(IDX_W)) i_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept),
        .strobe_o (strobe),
        .idx_o    (byte_idx),
        .done_o   (rec_done),
        .active_o (pacer_active)
    );

    fr_record_fmt #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) i_fmt (
        .idx_i     (byte_idx),
        .slot_i    (slot_q),
        .snap_lo_i (snap_lo),
        .snap_hi_i (snap_hi),
        .byte_o    (mem_wdata_o)
    );

    // Main sequencer: post-reset scan, idle wait, record write, slot advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            slot_q  <= '0;
            full_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SCAN: begin
                    if (mem_rdata_i == ERASED) begin
                        state_q <= ST_IDLE;
                    end else if (slot_q == SLOT_LAST) begin
                        full_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (rec_done) begin
                        state_q <= ST_IDLE;
                        if (slot_q == SLOT_LAST) begin
                            full_q <= 1'b1;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_addr_o = (state_q == ST_WRITE) ? {slot_q, byte_idx} : {slot_q, {IDX_W{1'b0}}};
    assign mem_we_o   = strobe;
    assign busy_o     = (state_q != ST_IDLE);
    assign full_o     = full_q;

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !mem_we_o); // R8
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> full_o); // R8
    AST_ACCEPT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mem_we_o); // R4
    AST_WRITE_MATCHES_PACER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> pacer_active); // R4
    AST_SCAN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SCAN) |=> (state_q != ST_SCAN)); // R6
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WRITE) && $past(state_q == ST_WRITE)) |-> $stable({snap_hi, snap_lo})); // R2
endmodule

// File: tb/test_fault_record_ctrl.sv
module test_fault_record_ctrl;
    localparam int SLOTS = 16;
    localparam int BC    = 5;
    localparam int NB    = SLOTS * 8;

    logic       clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic [7:0] flt_lo, flt_hi;
    logic       cap_req;
    logic       mem_we;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [7:0] stat_lo, stat_hi;
    logic       busy, full;

    logic [7:0] mem [0:NB-1];
    logic       mem_clear, pre_go;
    int         pre_lo, pre_hi;
    int         n_chk = 0, n_err = 0, n_wr = 0, cyc = 0;
    bit         wd_done = 0;

    fault_record_ctrl #(.SLOTS(SLOTS), .BYTE_CYCLES(BC)) i_fault_record_ctrl (
        .clk(clk), .rst_n(rst_n), .flt_lo_i(flt_lo), .flt_hi_i(flt_hi),
        .cap_req_i(cap_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .stat_lo_o(stat_lo), .stat_hi_o(stat_hi), .busy_o(busy), .full_o(full)
    );

    assign mem_rdata = mem[mem_addr];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Write-once record area model.
    always @(posedge clk) begin
        if (mem_clear) begin
            for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
        end else begin
            if (pre_go)
                for (int s = pre_lo; s <= pre_hi; s++) mem[s*8] <= 8'h50 | 8'(s);
            if (mem_we) begin
                chk(mem[mem_addr] == 8'hFF, "R5", "write to erased byte only", int'(mem[mem_addr]), 8'hFF);
                mem[mem_addr] <= mem_wdata;
                n_wr++;
            end
        end
    end

    // Behavioural reference model, advanced on every rising edge.
    int          m_state, m_slot, m_cnt, m_idx;
    bit          m_full, m_valid = 0, m_acc;
    logic [15:0] m_stat, m_snap;

    function automatic logic [7:0] exp_byte(input int idx, input int slot, input logic [15:0] snap);
        case (idx)
            0: return 8'h50 | 8'(slot);
            1: return snap[7:0];
            2: return snap[15:8];
            3: return ~snap[7:0];
            4: return ~snap[15:8];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_slot = 0; m_cnt = 0; m_idx = 0;
            m_full = 0; m_stat = '0; m_snap = '0; m_valid = 1;
        end else if (m_valid) begin
            m_acc = (m_state == 1) && cap_req && !m_full;
            if (m_acc) begin
                m_snap = m_stat | {flt_hi, flt_lo};
                m_stat = '0;
            end else begin
                m_stat = m_stat | {flt_hi, flt_lo};
            end
            case (m_state)
                0: begin
                    if (mem[m_slot*8] == 8'hFF) m_state = 1;
                    else if (m_slot == SLOTS - 1) begin m_full = 1; m_state = 1; end
                    else m_slot++;
                end
                1: if (m_acc) begin m_state = 2; m_cnt = 0; m_idx = 0; end
                default: begin
                    if (m_cnt == BC - 1) begin
                        m_cnt = 0;
                        if (m_idx == 7) begin
                            m_state = 1;
                            if (m_slot == SLOTS - 1) m_full = 1; else m_slot++;
                        end else m_idx++;
                    end else m_cnt++;
                end
            endcase
        end
    end

    // Compare the design with the model away from the rising edge.
    always @(negedge clk) begin
        if (m_valid && !wd_done) begin
            bit exp_we;
            exp_we = (m_state == 2) && (m_cnt == 0);
            chk(busy == (m_state != 1), (m_state == 2) ? "R4" : "R6", "busy", int'(busy), int'(m_state != 1));
            chk(full == m_full, "R8", "full", int'(full), int'(m_full));
            chk(mem_we == exp_we, "R4", "byte strobe", int'(mem_we), int'(exp_we));
            chk({stat_hi, stat_lo} == m_stat, "R1", "status", int'({stat_hi, stat_lo}), int'(m_stat));
            if (exp_we && mem_we) begin
                chk(int'(mem_addr) == m_slot*8 + m_idx, "R5", "address", int'(mem_addr), m_slot*8 + m_idx);
                chk(mem_wdata == exp_byte(m_idx, m_slot, m_snap), "R3", "record byte",
                    int'(mem_wdata), int'(exp_byte(m_idx, m_slot, m_snap)));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !wd_done) begin
            wd_done = 1;
            n_chk++; n_err++;
            $display("FAIL R4 watchdog: actual=%0d expected=%0d", cyc, 50000);
            summary();
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_idle();
        step();
        while (busy) step();
    endtask

    int w;
    initial begin
        rst_n = 0; mem_clear = 1; pre_go = 0; pre_lo = 0; pre_hi = 0;
        cap_req = 0; flt_lo = 0; flt_hi = 0;
        repeat (3) step();
        mem_clear = 0;
        step();
        // R9 reset state
        chk(busy == 1, "R9", "busy in reset", int'(busy), 1);
        chk(full == 0, "R9", "full in reset", int'(full), 0);
        chk(mem_we == 0, "R9", "strobe in reset", int'(mem_we), 0);
        chk({stat_hi, stat_lo} == 16'h0, "R9", "status in reset", int'({stat_hi, stat_lo}), 0);
        rst_n = 1;
        wait_idle();
        chk(busy == 0, "R6", "blank area scan done", int'(busy), 0);

        // R1 sticky status
        flt_lo = 8'h05; flt_hi = 8'h80; step();
        flt_lo = 8'h00; flt_hi = 8'h00; step(); step();
        chk(stat_lo == 8'h05, "R1", "low status held", int'(stat_lo), 8'h05);
        chk(stat_hi == 8'h80, "R1", "high status held", int'(stat_hi), 8'h80);

        // R2 capture with a fault present at the accepting edge, faults during write
        flt_lo = 8'h10; cap_req = 1; step();
        cap_req = 0; flt_lo = 8'hFF;
        chk({stat_hi, stat_lo} == 16'h0, "R2", "latch cleared on accept", int'({stat_hi, stat_lo}), 0);
        repeat (2) step();
        flt_lo = 8'h00;
        repeat (10) step();
        cap_req = 1; repeat (3) step(); cap_req = 0;   // R7 request while busy
        wait_idle();
        chk(mem[0] == 8'h50, "R3", "header slot 0", int'(mem[0]), 8'h50);
        chk(mem[1] == 8'h15, "R2", "low snapshot", int'(mem[1]), 8'h15);
        chk(mem[2] == 8'h80, "R2", "high snapshot", int'(mem[2]), 8'h80);
        chk(mem[3] == 8'hEA, "R3", "inverted low", int'(mem[3]), 8'hEA);
        chk(mem[4] == 8'h7F, "R3", "inverted high", int'(mem[4]), 8'h7F);
        chk(mem[7] == 8'h00, "R3", "pad byte", int'(mem[7]), 0);
        chk(mem[8] == 8'hFF, "R7", "busy request left slot 1 blank", int'(mem[8]), 8'hFF);
        chk(stat_lo == 8'hFF, "R1", "faults during write latched", int'(stat_lo), 8'hFF);

        cap_req = 1; step(); cap_req = 0;
        wait_idle();
        chk(mem[8] == 8'h51, "R3", "header slot 1", int'(mem[8]), 8'h51);
        chk(mem[9] == 8'hFF, "R2", "second snapshot low", int'(mem[9]), 8'hFF);

        // R6 rescan over a partly programmed area
        pre_lo = 2; pre_hi = 13; pre_go = 1; step(); pre_go = 0;
        rst_n = 0; repeat (2) step(); rst_n = 1; step();
        chk(busy == 1, "R6", "scan in progress", int'(busy), 1);
        wait_idle();
        flt_hi = 8'h3C; cap_req = 1; step(); cap_req = 0; flt_hi = 8'h00;
        wait_idle();
        chk(mem[112] == 8'h5E, "R6", "first blank slot used", int'(mem[112]), 8'h5E);
        chk(mem[114] == 8'h3C, "R3", "high snapshot slot 14", int'(mem[114]), 8'h3C);
        chk(full == 0, "R8", "not full yet", int'(full), 0);
        cap_req = 1; step(); cap_req = 0;
        wait_idle();
        chk(mem[120] == 8'h5F, "R6", "last slot used", int'(mem[120]), 8'h5F);
        chk(full == 1, "R8", "full after last slot", int'(full), 1);

        // R8 requests dropped when full
        w = n_wr;
        cap_req = 1; repeat (4) step(); cap_req = 0;
        repeat (10) step();
        chk(n_wr == w, "R8", "no write when full", n_wr, w);
        chk(busy == 0, "R8", "idle when full", int'(busy), 0);

        // Scan over a fully programmed area
        rst_n = 0; repeat (2) step(); rst_n = 1;
        wait_idle();
        chk(full == 1, "R6", "scan finds no blank slot", int'(full), 1);
        chk(n_wr == w, "R8", "no write after full scan", n_wr, w);

        wd_done = 1;
        summary();
        $finish;
    end
endmodule